// File: doc/BRIEF.md
# Compare and Auto-Reload System Timer

This block is a word-addressed timer that watches a 64-bit count supplied from outside, typically a free-running system counter. It can raise a level interrupt in two ways. In compare mode, the interrupt condition holds once the count reaches an absolute 64-bit threshold. That threshold can also be read and written as a signed 32-bit distance from the present count.

In auto-reload mode, the block keeps a 64-bit next-event value. Each time the count reaches that value, the block sets a sticky event flag and moves the next-event value to the current count plus a 32-bit step. Software clears the flag by writing zero to it. While auto-reload mode is on, the flag takes the place of the compare result as the timer status, and the compare path raises no interrupt.

Software drives the block through a 32-bit register bus. The bus has a byte address, a write enable and write data. Read data is returned in the same cycle. The block also holds a frequency word that software can write and read back, a capability word, and twelve read-only identification words. The count input is registered once, and every condition is evaluated from that registered copy. The interrupt output is registered as well.

Top module: `cmp_reload_timer`

## Requirements
- R1: After reset, the control, frequency, threshold, next-event, step and auto-control words read zero, and `irq_o` is low.
- R2: The control word at byte 0x2C holds run in bit 0 and mask in bit 1; writes keep only those two bits. Bit 2 reads the live status, and bits 31:3 read zero.
- R3: With auto-reload off, status is 1 exactly when run is 1 and the registered count is at least the 64-bit threshold, compared as unsigned. The threshold is written at bytes 0x20 (low half) and 0x24 (high half). Status is 0 whenever run is 0.
- R4: Reading byte 0x28 returns bits 31:0 of (threshold − count). Writing it sets the threshold to count plus the written word sign-extended to 64 bits.
- R5: `irq_o` is status AND NOT mask, registered, so it changes one clock after the registered count or a control write changes the condition.
- R6: The next-event value, read at bytes 0x40 and 0x44, is loaded with count + step (step at byte 0x48) on a write that changes the run bit or the auto-on bit. The load happens only when both bits are 1 after that write.
- R7: With run and auto-on both set and no load in that cycle, a count at or above the next-event value sets the event flag and re-arms the next-event value to count + step.
- R8: The auto-control word at byte 0x4C holds auto-on in bit 0 and the event flag in bit 1, and both bits read back. Writing 0 to bit 1 clears the flag; writing 1 leaves it as it was. A firing in the same cycle wins over a clear.
- R9: While auto-on is set, status equals run AND event flag, whatever the threshold is.
- R10: The count words (0x00, 0x04), the next-event words, the capability word (0x50) and the ID words (0xFD0–0xFFC) ignore writes. The capability word reads 1 in bits 3:0. ID word k, at byte 0xFD0 + 4k, reads byte k of the `ID_BYTES` parameter.
- R11: A read of any byte offset not listed in these requirements returns zero.
- R12: The frequency word at byte 0x10 stores all 32 written bits and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 64 | External incrementing count |
| addr_i | input | 12 | Byte address of the word access |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, same cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a firing in the same cycle as a software write to the auto-control word, or just after a run toggle has reloaded the next-event value. The stimulus reaches it with a zero step, which makes the block fire on every clock while the count advances. Bit-1 writes of 0 and 1 are then issued into that stream. Unsigned compares near the top of the 64-bit range are reached by moving the count there directly, since the count is an input.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 2 * DATA_W;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned ID_NUM = 12;

  localparam logic [WORD_W-1:0] W_COUNT_LO  = 10'h000;
  localparam logic [WORD_W-1:0] W_COUNT_HI  = 10'h001;
  localparam logic [WORD_W-1:0] W_FREQ      = 10'h004;
  localparam logic [WORD_W-1:0] W_CMP_LO    = 10'h008;
  localparam logic [WORD_W-1:0] W_CMP_HI    = 10'h009;
  localparam logic [WORD_W-1:0] W_DELTA     = 10'h00A;
  localparam logic [WORD_W-1:0] W_CTRL      = 10'h00B;
  localparam logic [WORD_W-1:0] W_AUTO_LO   = 10'h010;
  localparam logic [WORD_W-1:0] W_AUTO_HI   = 10'h011;
  localparam logic [WORD_W-1:0] W_STEP      = 10'h012;
  localparam logic [WORD_W-1:0] W_AUTO_CTRL = 10'h013;
  localparam logic [WORD_W-1:0] W_CAPS      = 10'h014;
  localparam logic [WORD_W-1:0] W_ID_FIRST  = 10'h3F4;
  localparam logic [WORD_W-1:0] W_ID_LAST   = 10'h3FF;

  localparam int unsigned CTRL_RUN  = 0;
  localparam int unsigned CTRL_MASK = 1;
  localparam int unsigned CTRL_STAT = 2;
  localparam int unsigned AUTO_ON   = 0;
  localparam int unsigned AUTO_EVT  = 1;
  localparam logic [3:0]  CAPS_AUTO = 4'd1;

  typedef struct packed {
    logic mask;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  cnt_q_i,
  output logic [DATA_W-1:0] freq_o,
  output logic [CNT_W-1:0]  cval_o,
  output logic [DATA_W-1:0] step_o,
  output ctrl_t             ctrl_o,
  output logic              auto_on_o,
  output logic              load_auto_o,
  output logic              evt_clr_o
);
  logic [DATA_W-1:0] freq_q, freq_d;
  logic [CNT_W-1:0]  cval_q, cval_d;
  logic [DATA_W-1:0] step_q, step_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              auto_q, auto_d;
  logic              wr_freq, wr_cmp_lo, wr_cmp_hi, wr_delta, wr_ctrl, wr_step, wr_auto;
  logic [CNT_W-1:0]  delta_ext;

  assign wr_freq   = wr_en_i && (word_i == W_FREQ);
  assign wr_cmp_lo = wr_en_i && (word_i == W_CMP_LO);
  assign wr_cmp_hi = wr_en_i && (word_i == W_CMP_HI);
  assign wr_delta  = wr_en_i && (word_i == W_DELTA);
  assign wr_ctrl   = wr_en_i && (word_i == W_CTRL);
  assign wr_step   = wr_en_i && (word_i == W_STEP);
  assign wr_auto   = wr_en_i && (word_i == W_AUTO_CTRL);
  assign delta_ext = {{DATA_W{wr_data_i[DATA_W-1]}}, wr_data_i};

  always_comb begin
    freq_d = freq_q;
    cval_d = cval_q;
    step_d = step_q;
    ctrl_d = ctrl_q;
    auto_d = auto_q;
    if (wr_freq)   freq_d = wr_data_i;
    if (wr_cmp_lo) cval_d = {cval_q[CNT_W-1:DATA_W], wr_data_i};
    if (wr_cmp_hi) cval_d = {wr_data_i, cval_q[DATA_W-1:0]};
    if (wr_delta)  cval_d = cnt_q_i + delta_ext;
    if (wr_step)   step_d = wr_data_i;
    if (wr_ctrl) begin
      ctrl_d.run  = wr_data_i[CTRL_RUN];
      ctrl_d.mask = wr_data_i[CTRL_MASK];
    end
    if (wr_auto)   auto_d = wr_data_i[AUTO_ON];
  end

  // reload the next-event value when either enable changes and both end up set
  always_comb begin
    load_auto_o = 1'b0;
    if (wr_ctrl && (ctrl_d.run != ctrl_q.run) && ctrl_d.run && auto_q)
      load_auto_o = 1'b1;
    if (wr_auto && (auto_d != auto_q) && auto_d && ctrl_q.run)
      load_auto_o = 1'b1;
  end

  assign evt_clr_o = wr_auto && !wr_data_i[AUTO_EVT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_q <= '0;
      cval_q <= '0;
      step_q <= '0;
      ctrl_q <= '0;
      auto_q <= 1'b0;
    end else if (wr_en_i) begin
      freq_q <= freq_d;
      cval_q <= cval_d;
      step_q <= step_d;
      ctrl_q <= ctrl_d;
      auto_q <= auto_d;
    end
  end

  assign freq_o    = freq_q;
  assign cval_o    = cval_q;
  assign step_o    = step_q;
  assign ctrl_o    = ctrl_q;
  assign auto_on_o = auto_q;
endmodule

// File: rtl/tmr_autoinc.sv
module tmr_autoinc
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_q_i,
  input  logic [DATA_W-1:0] step_i,
  input  logic              active_i,
  input  logic              load_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  aival_o,
  output logic              evt_o
);
  logic [CNT_W-1:0] aival_q, aival_d, rearm;
  logic             evt_q, evt_d, fire;

  assign rearm = cnt_q_i + {{(CNT_W-DATA_W){1'b0}}, step_i};
  assign fire  = active_i && !load_i && (cnt_q_i >= aival_q);

  always_comb begin
    aival_d = aival_q;
    evt_d   = evt_q;
    if (load_i || fire) aival_d = rearm;
    if (fire)           evt_d = 1'b1;
    else if (clr_i)     evt_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aival_q <= '0;
      evt_q   <= 1'b0;
    end else begin
      if (load_i || fire)  aival_q <= aival_d;
      if (fire || clr_i)   evt_q   <= evt_d;
    end
  end

  assign aival_o = aival_q;
  assign evt_o   = evt_q;
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
  import tmr_pkg::*;
#(
  parameter logic [8*ID_NUM-1:0] ID_BYTES = 96'h9E17002D_0006C3A5_00000004
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_q_i,
  input  logic [DATA_W-1:0] freq_i,
  input  logic [CNT_W-1:0]  cval_i,
  input  logic [DATA_W-1:0] step_i,
  input  ctrl_t             ctrl_i,
  input  logic              status_i,
  input  logic              auto_on_i,
  input  logic              evt_i,
  input  logic [CNT_W-1:0]  aival_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [CNT_W-1:0]  delta;
  logic [DATA_W-1:0] id_words [ID_NUM];
  logic [WORD_W-1:0] id_off;

  for (genvar k = 0; k < ID_NUM; k++) begin : g_id
    assign id_words[k] = {{(DATA_W-8){1'b0}}, ID_BYTES[8*k +: 8]};
  end

  assign delta  = cval_i - cnt_q_i;
  assign id_off = word_i - W_ID_FIRST;

  always_comb begin
    rd_data_o = '0;
    case (word_i)
      W_COUNT_LO:  rd_data_o = cnt_q_i[DATA_W-1:0];
      W_COUNT_HI:  rd_data_o = cnt_q_i[CNT_W-1:DATA_W];
      W_FREQ:      rd_data_o = freq_i;
      W_CMP_LO:    rd_data_o = cval_i[DATA_W-1:0];
      W_CMP_HI:    rd_data_o = cval_i[CNT_W-1:DATA_W];
      W_DELTA:     rd_data_o = delta[DATA_W-1:0];
      W_CTRL: begin
        rd_data_o[CTRL_RUN]  = ctrl_i.run;
        rd_data_o[CTRL_MASK] = ctrl_i.mask;
        rd_data_o[CTRL_STAT] = status_i;
      end
      W_AUTO_LO:   rd_data_o = aival_i[DATA_W-1:0];
      W_AUTO_HI:   rd_data_o = aival_i[CNT_W-1:DATA_W];
      W_STEP:      rd_data_o = step_i;
      W_AUTO_CTRL: begin
        rd_data_o[AUTO_ON]  = auto_on_i;
        rd_data_o[AUTO_EVT] = evt_i;
      end
      W_CAPS:      rd_data_o[3:0] = CAPS_AUTO;
      default: begin
        if (word_i >= W_ID_FIRST && word_i <= W_ID_LAST)
          rd_data_o = id_words[id_off[3:0]];
      end
    endcase
  end
endmodule

// File: rtl/cmp_reload_timer.sv
module cmp_reload_timer
  import tmr_pkg::*;
#(
  parameter logic [8*ID_NUM-1:0] ID_BYTES = 96'h9E17002D_0006C3A5_00000004
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] freq, step;
  logic [CNT_W-1:0]  cval, aival;
  ctrl_t             ctrl;
  logic              auto_on, load_auto, evt_clr, evt;
  logic              status, irq_d, irq_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_i;
  end

  assign word = addr_i[ADDR_W-1:2];

  tmr_ctrl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en_i),
    .word_i      (word),
    .wr_data_i   (wr_data_i),
    .cnt_q_i     (cnt_q),
    .freq_o      (freq),
    .cval_o      (cval),
    .step_o      (step),
    .ctrl_o      (ctrl),
    .auto_on_o   (auto_on),
    .load_auto_o (load_auto),
    .evt_clr_o   (evt_clr)
  );

  tmr_autoinc u_auto (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .cnt_q_i  (cnt_q),
    .step_i   (step),
    .active_i (ctrl.run && auto_on),
    .load_i   (load_auto),
    .clr_i    (evt_clr),
    .aival_o  (aival),
    .evt_o    (evt)
  );

  assign status = ctrl.run && (auto_on ? evt : (cnt_q >= cval));
  assign irq_d  = status && !ctrl.mask;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  tmr_rd_mux #(.ID_BYTES(ID_BYTES)) u_rd (
    .word_i    (word),
    .cnt_q_i   (cnt_q),
    .freq_i    (freq),
    .cval_i    (cval),
    .step_i    (step),
    .ctrl_i    (ctrl),
    .status_i  (status),
    .auto_on_i (auto_on),
    .evt_i     (evt),
    .aival_i   (aival),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [DATA_W-1:0] step,
  input logic [CNT_W-1:0]  aival,
  input logic              run,
  input logic              mask,
  input logic              auto_on,
  input logic              evt
);
  // R5
  mask_blocks_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mask && $past(mask)) |-> !irq_o);

  // R3
  irq_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> $past(run));

  // R7
  evt_needs_auto_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(evt) |-> $past(run && auto_on));

  // R7
  rearm_on_event_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(evt) |-> (aival == $past(cnt_q) + {32'b0, $past(step)}));

  always_comb begin
    if (rst_n && addr_i[ADDR_W-1:2] == W_CTRL) begin
      // R2
      ctrl_upper_zero_chk: assert (rd_data_o[DATA_W-1:3] == '0);
    end
    if (rst_n && addr_i[ADDR_W-1:2] == W_CAPS) begin
      // R10
      caps_value_chk: assert (rd_data_o == 32'd1);
    end
  end
endmodule

bind cmp_reload_timer tmr_chk u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n),
  .addr_i    (addr_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .cnt_q     (cnt_q),
  .step      (step),
  .aival     (aival),
  .run       (ctrl.run),
  .mask      (ctrl.mask),
  .auto_on   (auto_on),
  .evt       (evt)
);

// File: tb/cmp_reload_timer_tb_top.sv
module cmp_reload_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] cnt_drv = '0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        irq;

  localparam logic [95:0] IDS = 96'h9E17002D_0006C3A5_00000004;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";
  bit checking = 1'b0;
  logic [63:0] cstep = 0;

  always #2.5 clk = ~clk;

  cmp_reload_timer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_i(cnt_drv), .addr_i(addr),
    .wr_en_i(we), .wr_data_i(wdata), .rd_data_o(rd_data), .irq_o(irq)
  );

  // behavioural reference state
  logic [63:0] m_cnt = 0, m_cval = 0, m_ai = 0;
  logic [31:0] m_freq = 0, m_step = 0;
  bit m_run = 0, m_mask = 0, m_auto = 0, m_evt = 0, m_irq = 0;

  function automatic bit m_status();
    if (!m_run) return 1'b0;
    if (m_auto) return m_evt;
    return m_cnt >= m_cval;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cnt = 0; m_cval = 0; m_ai = 0; m_freq = 0; m_step = 0;
      m_run = 0; m_mask = 0; m_auto = 0; m_evt = 0; m_irq = 0;
    end else begin
      bit load, fire, clr, n_run, n_auto;
      m_irq = m_status() && !m_mask;
      load = 0; clr = 0; n_run = m_run; n_auto = m_auto;
      if (we) begin
        case (addr)
          12'h010: m_freq = wdata;
          12'h020: m_cval[31:0] = wdata;
          12'h024: m_cval[63:32] = wdata;
          12'h028: m_cval = m_cnt + {{32{wdata[31]}}, wdata};
          12'h02C: begin
            n_run = wdata[0]; m_mask = wdata[1];
            if (n_run && !m_run && m_auto) load = 1;
          end
          12'h048: m_step = wdata;
          12'h04C: begin
            n_auto = wdata[0]; clr = !wdata[1];
            if (n_auto && !m_auto && m_run) load = 1;
          end
          default: ;
        endcase
      end
      fire = !load && m_run && m_auto && (m_cnt >= m_ai);
      if (load || fire) m_ai = m_cnt + {32'b0, m_step};
      if (fire) m_evt = 1; else if (clr) m_evt = 0;
      m_run = n_run; m_auto = n_auto;
      m_cnt = cnt_drv;
    end
  end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [63:0] d;
    d = m_cval - m_cnt;
    case (a)
      12'h000: return m_cnt[31:0];
      12'h004: return m_cnt[63:32];
      12'h010: return m_freq;
      12'h020: return m_cval[31:0];
      12'h024: return m_cval[63:32];
      12'h028: return d[31:0];
      12'h02C: return {29'b0, m_status(), m_mask, m_run};
      12'h040: return m_ai[31:0];
      12'h044: return m_ai[63:32];
      12'h048: return m_step;
      12'h04C: return {30'b0, m_evt, m_auto};
      12'h050: return 32'd1;
      default: begin
        if (a >= 12'hFD0 && a[1:0] == 2'b00) return {24'b0, IDS[8*((a-12'hFD0)>>2) +: 8]};
        return 32'd0;
      end
    endcase
  endfunction

  task automatic compare();
    vectors++;
    if (rd_data !== m_read(addr)) begin
      fails++;
      $display("FAIL %s rd_data addr=%h act=%h exp=%h", cur_req, addr, rd_data, m_read(addr));
    end
    if (irq !== m_irq) begin
      fails++;
      $display("FAIL %s irq_o act=%b exp=%b", cur_req, irq, m_irq);
    end
  endtask

  task automatic cyc(input logic [11:0] a, input bit w, input logic [31:0] d);
    @(negedge clk);
    if (checking) compare();
    addr = a; we = w; wdata = d;
    cnt_drv = cnt_drv + cstep;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(a, 1'b1, d);
  endtask

  task automatic rd(input logic [11:0] a, input int n);
    for (int i = 0; i < n; i++) cyc(a, 1'b0, 32'd0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    checking = 1'b1;
    // R1 reset values
    cur_req = "R1";
    rd(12'h02C, 1); rd(12'h010, 1); rd(12'h020, 1); rd(12'h040, 1);
    rd(12'h048, 1); rd(12'h04C, 1); rd(12'h028, 1);
    cnt_drv = 64'hFFFF_FFF8; cstep = 1;
    rd(12'h000, 3); rd(12'h004, 10);
    // R12 frequency
    cur_req = "R12";
    wr(12'h010, 32'h1234_ABCD); rd(12'h010, 2);
    // R2 control bit filter
    cur_req = "R2";
    wr(12'h02C, 32'hFFFF_FFFC); rd(12'h02C, 2);
    wr(12'h02C, 32'hFFFF_FFFE); rd(12'h02C, 2);
    wr(12'h02C, 32'h0); rd(12'h02C, 1);
    // R3 compare crossing, R5 irq latency
    cur_req = "R3";
    wr(12'h024, 32'h1); wr(12'h020, 32'h18);
    wr(12'h02C, 32'h1);
    cur_req = "R5";
    rd(12'h02C, 20);
    wr(12'h02C, 32'h3); rd(12'h02C, 3);
    wr(12'h02C, 32'h1); rd(12'h02C, 3);
    wr(12'h02C, 32'h0); rd(12'h02C, 2);
    wr(12'h02C, 32'h1);
    // R4 relative view
    cur_req = "R4";
    wr(12'h028, 32'hFFFF_FFF0); rd(12'h028, 3); rd(12'h020, 1); rd(12'h024, 1);
    wr(12'h028, 32'd12); rd(12'h028, 16); rd(12'h02C, 2);
    // R10 read-only words
    cur_req = "R10";
    wr(12'h000, 32'hDEAD_BEEF); rd(12'h000, 1);
    wr(12'h004, 32'hDEAD_BEEF); rd(12'h004, 1);
    wr(12'h040, 32'h5555_5555); rd(12'h040, 1);
    wr(12'h044, 32'h5555_5555); rd(12'h044, 1);
    wr(12'h050, 32'hFFFF_FFFF); rd(12'h050, 1);
    wr(12'hFD0, 32'hFF); rd(12'hFD0, 1);
    for (int k = 0; k < 12; k++) rd(12'hFD0 + 12'(4*k), 1);
    // R11 unmapped reads
    cur_req = "R11";
    rd(12'h008, 1); rd(12'h054, 1); rd(12'h800, 1); rd(12'hFCC, 1); rd(12'h030, 1);
    // R6 auto-reload load on enable change
    cur_req = "R6";
    wr(12'h02C, 32'h0); wr(12'h048, 32'd6);
    wr(12'h04C, 32'h1); rd(12'h040, 2);
    wr(12'h02C, 32'h1); rd(12'h040, 2); rd(12'h044, 1);
    // R9 status follows flag; compare path silent
    cur_req = "R9";
    wr(12'h024, 32'hFFFF_FFFF);
    // R7 periodic firing
    cur_req = "R7";
    rd(12'h02C, 3); rd(12'h040, 10); rd(12'h04C, 4);
    // R8 flag clear semantics
    cur_req = "R8";
    wr(12'h04C, 32'h3); rd(12'h04C, 1);
    wr(12'h04C, 32'h1); rd(12'h04C, 1); rd(12'h02C, 8);
    cur_req = "R9";
    wr(12'h04C, 32'h1); wr(12'h024, 32'h0); wr(12'h020, 32'h0); rd(12'h02C, 2);
    // R6 toggle auto-on re-arms
    cur_req = "R6";
    wr(12'h04C, 32'h0); rd(12'h02C, 3); wr(12'h04C, 32'h1); rd(12'h040, 3);
    // R8 zero step: firing every cycle races clears
    cur_req = "R8";
    wr(12'h048, 32'd0); rd(12'h04C, 3);
    wr(12'h04C, 32'h1); wr(12'h04C, 32'h3); rd(12'h040, 3);
    wr(12'h02C, 32'h3); wr(12'h04C, 32'h1); rd(12'h02C, 3);
    // R3 unsigned compare near top of range
    cur_req = "R3";
    wr(12'h02C, 32'h0); wr(12'h04C, 32'h2);
    cnt_drv = 64'hFFFF_FFFF_FFFF_FFE8;
    wr(12'h024, 32'hFFFF_FFFF); wr(12'h020, 32'hFFFF_FFF8);
    wr(12'h02C, 32'h1); rd(12'h02C, 20);
    cstep = 0; rd(12'h028, 3);
    checking = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule